// File: doc/BRIEF.md
# Serial Management Register Responder

This block answers register read and write transactions that a station manager sends over the two-wire serial management bus. The manager supplies a management clock together with a data bit and an output-enable. The block returns one data bit on its own output. The block runs on a fast system clock and samples the management clock as an ordinary input. On each low-to-high transition of that clock it shifts in one bit, which counts as 1 only while the manager both drives the line and holds it high.

A run of 32 ones in the shift register synchronises the block to a frame. Sixteen header bits follow. They carry a start code, an opcode, a PHY address, a register address and two turnaround bits. For a read, the block returns the addressed 16-bit register most significant bit first over the next 16 transitions. For a write, it collects 16 data bits and stores them on the last of them. The register file holds 32 words. Two of them are fixed identifier words that reset to nonzero values and cannot be written.

Top module: `mdio_resp`

## Requirements
- R1: A bit enters the shift register only on a rising transition of `mdc` as seen at a `clk` edge, and that bit is 1 only when `mdo` and `mdoe` are both high; a one driven with `mdoe` low counts as 0.
- R2: A frame is recognised only after the 32-bit shift register holds all ones; a run of 31 ones followed by a header produces no response.
- R3: The 16 header bits, with the first received bit as bit 15, are: start code in bits 15:14 (must be 01), opcode in bits 13:12 (01 write, 10 read), PHY address in bits 11:7, register address in bits 6:2 and turnaround in bits 1:0. Every PHY address is answered.
- R4: A write header is accepted only when the turnaround equals 10. A read header is accepted whenever turnaround bit 0 is 0, so 00 and 10 both work. Any other header, including a wrong start code, leaves the registers and `mdi` unchanged.
- R5: On an accepted read, the addressed register appears on `mdi` most significant bit first, one bit per rising `mdc` transition, over the 16 transitions after the header. `mdi` changes only at such transitions and holds its last value otherwise.
- R6: On an accepted write, the 16 bits received after the header are stored into the addressed register on the 16th of those transitions, with the first data bit as bit 15.
- R7: After reset, register 2 reads 0x0022, register 3 reads 0x161A and every other register reads 0.
- R8: Writes to registers 2 and 3 are discarded; all other registers store written data.
- R9: The data bits of a completed write also count toward the next preamble: a write of 0xFFFF followed by only 16 ones synchronises the next frame.
- R10: While `rstN` is low, `mdi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the management signals |
| rstN | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdo | input | 1 | Serial data driven by the manager |
| mdoe | input | 1 | High while the manager drives the data line |
| mdi | output | 1 | Serial data returned to the manager during reads |

## Verification
On a single management clock edge, the commit of a write can coincide with the growth of the next preamble. The bits being stored are the same bits that fill the shift register toward the all-ones sync pattern. The bench provokes this by writing 0xFFFF and then sending only 16 ones before a read header to that register. It judges the case by requiring the read to return 0xFFFF, which shows both that the store happened and that the shortened preamble was honoured. Randomised frames with legal and illegal turnarounds are compared against a bench register model to cover the ordinary cases around this overlap.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;
  localparam int DATA_W   = 16;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int SHIFT_W  = 2 * DATA_W;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_READ  = 2'd1,
    FS_WRITE = 2'd2
  } frame_state_t;

  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic              loadOut;
    logic              shiftOut;
    logic              commit;
    logic [REG_AW-1:0] regAddr;
    logic [DATA_W-1:0] wrData;
  } dp_ctl_t;
endpackage

// File: rtl/mdio_resp_ctrl.sv
module mdio_resp_ctrl
  import mdio_resp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    mdc,
  input  logic    mdo,
  input  logic    mdoe,
  output dp_ctl_t ctl
);
  localparam int CNT_W = $clog2(SHIFT_W + 1);
  localparam logic [CNT_W-1:0] CNT_SYNC = CNT_W'(SHIFT_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(DATA_W);

  logic               mdcPrev;
  logic [SHIFT_W-1:0] shiftQ;
  logic [CNT_W-1:0]   cntQ;
  frame_state_t       stateQ;
  logic [REG_AW-1:0]  addrQ;

  logic               riseEdge;
  logic               bitIn;
  logic [SHIFT_W-1:0] shiftNext;
  logic [CNT_W-1:0]   cntEff;
  logic [DATA_W-1:0]  hdr;
  logic               startOk;
  logic               wrOk;
  logic               rdOk;
  logic               atHdr;
  frame_state_t       stateMid;
  frame_state_t       stateNext;
  logic [REG_AW-1:0]  addrMid;
  logic [CNT_W-1:0]   cntNext;

  always_comb begin
    riseEdge  = mdc & ~mdcPrev;
    bitIn     = mdo & mdoe;
    shiftNext = {shiftQ[SHIFT_W-2:0], bitIn};
    cntEff    = (&shiftNext) ? CNT_SYNC : cntQ;
    hdr       = shiftNext[DATA_W-1:0];
    startOk   = (hdr[15:14] == 2'b01);
    wrOk      = startOk && (hdr[13:12] == 2'b01) && (hdr[1:0] == 2'b10);
    rdOk      = startOk && (hdr[13:12] == 2'b10) && !hdr[0];
    atHdr     = (cntEff == CNT_HDR);

    stateMid = stateQ;
    addrMid  = addrQ;
    if (atHdr) begin
      stateMid = wrOk ? FS_WRITE : (rdOk ? FS_READ : FS_IDLE);
      if (wrOk || rdOk) addrMid = hdr[6:2];
    end

    stateNext = (cntEff == '0) ? FS_IDLE : stateMid;
    cntNext   = (cntEff == '0) ? '0 : cntEff - 1'b1;

    ctl.loadOut  = riseEdge && atHdr && rdOk;
    ctl.shiftOut = riseEdge && (cntEff < CNT_HDR) && (stateMid == FS_READ);
    ctl.commit   = riseEdge && (cntEff == '0) && (stateMid == FS_WRITE);
    ctl.regAddr  = addrMid;
    ctl.wrData   = shiftNext[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcPrev <= 1'b0;
      shiftQ  <= '0;
      cntQ    <= '0;
      stateQ  <= FS_IDLE;
      addrQ   <= '0;
    end else begin
      mdcPrev <= mdc;
      if (riseEdge) begin
        shiftQ <= shiftNext;
        cntQ   <= cntNext;
        stateQ <= stateNext;
        addrQ  <= addrMid;
      end
    end
  end
endmodule

// File: rtl/mdio_resp_datapath.sv
module mdio_resp_datapath
  import mdio_resp_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD_HI = 16'h0022,
  parameter logic [DATA_W-1:0] ID_WORD_LO = 16'h161A,
  parameter int                ID_IDX_HI  = 2,
  parameter int                ID_IDX_LO  = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  dp_ctl_t ctl,
  output logic    mdi
);
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] outShQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == ID_IDX_HI) begin : g_id_hi
      assign regQ[i] = ID_WORD_HI;
    end else if (i == ID_IDX_LO) begin : g_id_lo
      assign regQ[i] = ID_WORD_LO;
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rstN) regQ[i] <= '0;
        else if (ctl.commit && (ctl.regAddr == REG_AW'(i))) regQ[i] <= ctl.wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShQ <= '0;
      mdi    <= 1'b0;
    end else if (ctl.loadOut) begin
      outShQ <= regQ[ctl.regAddr];
    end else if (ctl.shiftOut) begin
      mdi    <= outShQ[DATA_W-1];
      outShQ <= {outShQ[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mdio_resp.sv
module mdio_resp
  import mdio_resp_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD_HI = 16'h0022,
  parameter logic [DATA_W-1:0] ID_WORD_LO = 16'h161A,
  parameter int                ID_IDX_HI  = 2,
  parameter int                ID_IDX_LO  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdc,
  input  logic mdo,
  input  logic mdoe,
  output logic mdi
);
  dp_ctl_t ctlBus;

  mdio_resp_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .mdc  (mdc),
    .mdo  (mdo),
    .mdoe (mdoe),
    .ctl  (ctlBus)
  );

  mdio_resp_datapath #(
    .ID_WORD_HI (ID_WORD_HI),
    .ID_WORD_LO (ID_WORD_LO),
    .ID_IDX_HI  (ID_IDX_HI),
    .ID_IDX_LO  (ID_IDX_LO)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctlBus),
    .mdi  (mdi)
  );
endmodule

// File: rtl/mdio_resp_chk.sv
module mdio_resp_chk
  import mdio_resp_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    mdc,
  input logic    mdi,
  input dp_ctl_t ctl
);
  logic [4:0] shLeft;

  always_ff @(posedge clk) begin
    if (!rstN) shLeft <= '0;
    else if (ctl.loadOut) shLeft <= 5'd16;
    else if (ctl.shiftOut && (shLeft != '0)) shLeft <= shLeft - 1'b1;
  end

  AST_ACTION_ON_MDC_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadOut || ctl.shiftOut || ctl.commit) |-> mdc); // R1

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadOut, ctl.shiftOut, ctl.commit})); // R4

  AST_MDI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftOut |=> $stable(mdi)); // R5

  AST_SHIFT_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftOut |-> (shLeft != '0)); // R5

  AST_MDI_RESET: assert property (@(posedge clk)
    !rstN |=> !mdi); // R10
endmodule

bind mdio_resp mdio_resp_chk u_chk (
  .clk  (clk),
  .rstN (rstN),
  .mdc  (mdc),
  .mdi  (mdi),
  .ctl  (ctlBus)
);

// File: tb/mdio_resp_test.sv
module mdio_resp_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdc = 1'b0;
  logic mdo = 1'b0;
  logic mdoe = 1'b0;
  logic mdi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model [32];

  always #2 clk = ~clk;

  mdio_resp uut (
    .clk  (clk),
    .rstN (rstN),
    .mdc  (mdc),
    .mdo  (mdo),
    .mdoe (mdoe),
    .mdi  (mdi)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic d, input logic oe);
    @(negedge clk);
    mdo = d; mdoe = oe; mdc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mdc = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mkHdr(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] ra, input logic [1:0] ta);
    return {2'b01, op, phy, ra, ta};
  endfunction

  // preamble of pre ones, a 16-bit header, then 16 data bits
  task automatic frame(input int pre, input logic [15:0] hdr, input bit isRead,
                       input logic [15:0] wdata, output logic [15:0] rdVal);
    rdVal = '0;
    for (int i = 0; i < pre; i++) sendBit(1'b1, 1'b1);
    for (int i = 15; i >= 0; i--) sendBit(hdr[i], 1'b1);
    for (int i = 15; i >= 0; i--) begin
      if (isRead) begin
        sendBit(1'b0, 1'b0);
        rdVal = {rdVal[14:0], mdi};
      end else begin
        sendBit(wdata[i], 1'b1);
      end
    end
  endtask

  task automatic doWrite(input logic [4:0] phy, input logic [4:0] ra,
                         input logic [1:0] ta, input logic [15:0] d);
    logic [15:0] dummy;
    frame(32, mkHdr(2'b01, phy, ra, ta), 1'b0, d, dummy);
    if (ta == 2'b10 && ra != 5'd2 && ra != 5'd3) model[ra] = d;
  endtask

  task automatic doRead(input string req, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [1:0] ta);
    logic [15:0] v;
    frame(32, mkHdr(2'b10, phy, ra, ta), 1'b1, 16'h0, v);
    chk(req, v, model[ra]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] exp;
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    model[2] = 16'h0022;
    model[3] = 16'h161A;
    void'($urandom(32'd4711));

    repeat (4) @(negedge clk);
    chk("R10 mdi in reset", {15'h0, mdi}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 mdi after reset", {15'h0, mdi}, 16'h0);

    // R7: every register at its reset value
    for (int r = 0; r < 32; r++) doRead("R7 reset value", 5'd1, 5'(r), 2'b00);

    // R8: identifier registers are protected
    doWrite(5'd1, 5'd2, 2'b10, 16'hBEEF);
    doRead("R8 id word 2 kept", 5'd1, 5'd2, 2'b00);
    doWrite(5'd1, 5'd3, 2'b10, 16'h1234);
    doRead("R8 id word 3 kept", 5'd1, 5'd3, 2'b00);

    // R6 / R5: plain write then read, MSB-first pattern
    doWrite(5'd0, 5'd9, 2'b10, 16'h8001);
    doRead("R6 write stored / R5 msb first", 5'd0, 5'd9, 2'b00);
    // R4: read with turnaround 10 is also accepted
    doRead("R4 read ta 10 accepted", 5'd0, 5'd9, 2'b10);

    // R4: write with bad turnaround is dropped
    doWrite(5'd0, 5'd9, 2'b11, 16'h5555);
    doRead("R4 write ta 11 ignored", 5'd0, 5'd9, 2'b00);
    doWrite(5'd0, 5'd9, 2'b00, 16'h5555);
    doRead("R4 write ta 00 ignored", 5'd0, 5'd9, 2'b00);

    // R4: read with turnaround bit 0 set gives no response
    doRead("R4 prep", 5'd0, 5'd2, 2'b00);
    exp = {16{mdi}};
    frame(32, mkHdr(2'b10, 5'd0, 5'd3, 2'b01), 1'b1, 16'h0, v);
    chk("R4 read ta 01 rejected", v, exp);

    // R4: wrong start code gives no response
    doRead("R4 prep", 5'd0, 5'd2, 2'b00);
    exp = {16{mdi}};
    frame(32, {2'b11, 2'b10, 5'd0, 5'd3, 2'b00}, 1'b1, 16'h0, v);
    chk("R4 bad start rejected", v, exp);

    // R2: 31 ones do not synchronise
    doRead("R2 prep", 5'd0, 5'd2, 2'b00);
    exp = {16{mdi}};
    frame(31, mkHdr(2'b10, 5'd0, 5'd3, 2'b00), 1'b1, 16'h0, v);
    chk("R2 short preamble ignored", v, exp);

    // R1: a one driven with mdoe low counts as 0 and breaks the preamble
    doRead("R1 prep", 5'd0, 5'd2, 2'b00);
    exp = {16{mdi}};
    for (int i = 0; i < 32; i++) sendBit(1'b1, (i != 10));
    frame(0, mkHdr(2'b10, 5'd0, 5'd3, 2'b00), 1'b1, 16'h0, v);
    chk("R1 undriven one is zero", v, exp);

    // R9: write commit overlaps the next preamble
    doWrite(5'd4, 5'd7, 2'b10, 16'hFFFF);
    frame(16, mkHdr(2'b10, 5'd4, 5'd7, 2'b00), 1'b1, 16'h0, v);
    chk("R9 short preamble after ffff write", v, 16'hFFFF);

    // R3 / R6 / R8: random frames, any PHY address answered
    for (int n = 0; n < 60; n++) begin
      logic [4:0] ra;
      logic [4:0] phy;
      logic [1:0] ta;
      ra  = 5'($urandom_range(0, 31));
      phy = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 0) begin
        ta = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b10;
        doWrite(phy, ra, ta, 16'($urandom));
      end else begin
        doRead("R3 random read any phy", phy, ra, ($urandom_range(0, 1) == 0) ? 2'b00 : 2'b10);
      end
    end
    for (int r = 0; r < 32; r++) doRead("R6 final contents", 5'd31, 5'(r), 2'b00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule